// File: doc/BRIEF.md
# Slave-Mode Input Acquisition Sequencer

This block runs the on-line, slave-mode side of a controller that takes its input variables from a host. The host writes 8-bit values one at a time. With each value it puts a 3-bit slot identifier on the select bus, so values can arrive in any order. The block captures a value on the rising edge of the active read strobe. Captured values stay in a bank of slot registers until the same slot is written again, so a slowly changing variable does not have to be sent again.

When the last-input signal is seen while idle, the block enters its processing run. It computes a fixed number of output values. Each one takes a fixed latency from a deterministic placeholder function of the stored slots. A wait input can hold a finished value back from the output until it is released. Busy stays active for the whole run. When the run ends, a one-cycle start-conversion strobe asks for the next conversion, unless auto mode suppresses it. An active-low output enable drives a separate drive-enable flag that stands in for tri-state control.

Top module: `slave_acq_seq`

## Requirements
- R1: On a rising edge of the active read strobe while idle, the byte on `data_i` is stored into the slot selected by `sel_i` (slot number = binary value of `sel_i`); both are sampled at that same clock edge.
- R2: Slots may be written in any order; a slot that is not rewritten keeps its value across any number of processing runs.
- R3: While busy, read strobes are ignored: no slot changes and no ready pulse is issued.
- R4: Each capture produces a ready pulse of exactly one cycle, visible in the cycle right after the capturing edge.
- R5: The last-input signal sampled active while idle makes busy active from the next cycle. Exactly NUM_OUT outputs follow, and busy goes inactive at the same edge that presents the last output.
- R6: Output k (k = 0..NUM_OUT-1) equals (slot[k mod 8] + slot[(k+1) mod 8] + k) mod 256. It is presented with a one-cycle `out_stb_o` and `out_idx_o` = k. With wait inactive, outputs appear CALC_LAT cycles apart, the first CALC_LAT cycles after busy rises.
- R7: If wait is active at the edge where an output would be presented, that output is held back. It is presented at the first edge where wait is inactive, and `out_o` keeps its previous value meanwhile.
- R8: Busy going inactive is accompanied by a one-cycle start-conversion pulse, unless `auto_i` was high at that edge; then no pulse is issued.
- R9: `out_en_o` is high exactly when `oe_ni` is low.
- R10: Read, last-input, wait, ready, busy and start-conversion each have a polarity parameter; with default parameters all are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_i | input | 1 | Auto mode; suppresses the start-conversion pulse |
| rd_i | input | 1 | Read strobe (polarity by RD_HI) |
| sel_i | input | ID_W | Slot identifier for the write |
| data_i | input | DATA_W | Input value |
| lastin_i | input | 1 | Last input given; start processing (polarity by LASTIN_HI) |
| wait_i | input | 1 | Hold finished outputs (polarity by WAIT_HI) |
| oe_ni | input | 1 | Output enable, active low |
| ready_o | output | 1 | Capture acknowledge pulse (polarity by READY_HI) |
| busy_o | output | 1 | Processing run in progress (polarity by BUSY_HI) |
| soc_o | output | 1 | Start-conversion pulse (polarity by SOC_HI) |
| out_o | output | DATA_W | Presented output value |
| out_en_o | output | 1 | Output drive enable (low means high impedance) |
| out_stb_o | output | 1 | One-cycle pulse when a new output is presented |
| out_idx_o | output | clog2(NUM_OUT) | Index of the presented output |

## Verification
The hardest case to reach from the ports is a read strobe that lands in the middle of a run. It has to be shown to leave no trace, and that can only be seen through the values of later runs. The stimulus fires a random write a few cycles into selected runs. It then starts a later run without rewriting those slots and compares every output with a model that never took the ignored write. Wait is toggled at random inside runs, so outputs are held back, some more than once and some at the final output. This exercises the hold path together with the busy fall and the start-conversion pulse.

// File: rtl/slave_acq_pkg.sv
package slave_acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/acq_input_bank.sv
module acq_input_bank #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3,
  localparam int NUM_SLOTS = 1 << ID_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cap_en_i,
  input  logic                          rd_i,
  input  logic [ID_W-1:0]               sel_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic                          ready_o,
  output logic [NUM_SLOTS*DATA_W-1:0]   regs_o
);
  logic rd_prev_q;
  logic cap;

  assign cap = rd_i & ~rd_prev_q & cap_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_prev_q <= 1'b0;
      ready_o   <= 1'b0;
    end else begin
      rd_prev_q <= rd_i;
      ready_o   <= cap;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[g*DATA_W +: DATA_W] <= '0;
      else if (cap && (sel_i == ID_W'(g)))
        regs_o[g*DATA_W +: DATA_W] <= data_i;
    end
  end
endmodule

// File: rtl/acq_out_seq.sv
module acq_out_seq
  import slave_acq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ID_W     = 3,
  parameter int NUM_OUT  = 4,
  parameter int CALC_LAT = 4,
  localparam int NUM_SLOTS = 1 << ID_W,
  localparam int IDX_W     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int LAT_W     = $clog2(CALC_LAT + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        lastin_i,
  input  logic                        wait_i,
  input  logic                        auto_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] regs_i,
  output logic                        busy_o,
  output logic                        idle_o,
  output logic [DATA_W-1:0]           out_o,
  output logic                        out_stb_o,
  output logic [IDX_W-1:0]            out_idx_o,
  output logic                        soc_o
);
  seq_state_e         state_q;
  logic [LAT_W-1:0]   lat_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ID_W-1:0]    slot_a, slot_b;
  logic [DATA_W-1:0]  result;
  logic               calc_done, present, last_out;

  // placeholder engine: two neighbouring slots plus the output index
  always_comb begin
    slot_a = ID_W'(idx_q % NUM_SLOTS);
    slot_b = slot_a + 1'b1;
    result = regs_i[slot_a*DATA_W +: DATA_W] + regs_i[slot_b*DATA_W +: DATA_W]
           + DATA_W'(idx_q);
  end

  assign calc_done = (state_q == ST_CALC) && (lat_q == LAT_W'(CALC_LAT - 1));
  assign present   = ((state_q == ST_CALC) && calc_done && !wait_i) ||
                     ((state_q == ST_HOLD) && !wait_i);
  assign last_out  = (idx_q == IDX_W'(NUM_OUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lat_q     <= '0;
      idx_q     <= '0;
      out_o     <= '0;
      out_stb_o <= 1'b0;
      out_idx_o <= '0;
      soc_o     <= 1'b0;
    end else begin
      out_stb_o <= 1'b0;
      soc_o     <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (lastin_i) begin
            state_q <= ST_CALC;
            lat_q   <= '0;
            idx_q   <= '0;
          end
        end
        ST_CALC: begin
          if (!calc_done) lat_q <= lat_q + 1'b1;
          else if (wait_i) state_q <= ST_HOLD;
        end
        ST_HOLD: ;
        default: state_q <= ST_IDLE;
      endcase
      if (present) begin
        out_o     <= result;
        out_stb_o <= 1'b1;
        out_idx_o <= idx_q;
        lat_q     <= '0;
        if (last_out) begin
          state_q <= ST_IDLE;
          soc_o   <= !auto_i;
        end else begin
          state_q <= ST_CALC;
          idx_q   <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/slave_acq_seq.sv
module slave_acq_seq #(
  parameter int DATA_W    = 8,
  parameter int ID_W      = 3,
  parameter int NUM_OUT   = 4,
  parameter int CALC_LAT  = 4,
  parameter bit RD_HI     = 1'b1,
  parameter bit LASTIN_HI = 1'b1,
  parameter bit WAIT_HI   = 1'b1,
  parameter bit READY_HI  = 1'b1,
  parameter bit BUSY_HI   = 1'b1,
  parameter bit SOC_HI    = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                auto_i,
  input  logic                rd_i,
  input  logic [ID_W-1:0]     sel_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                lastin_i,
  input  logic                wait_i,
  input  logic                oe_ni,
  output logic                ready_o,
  output logic                busy_o,
  output logic                soc_o,
  output logic [DATA_W-1:0]   out_o,
  output logic                out_en_o,
  output logic                out_stb_o,
  output logic [((NUM_OUT > 1) ? $clog2(NUM_OUT) : 1)-1:0] out_idx_o
);
  localparam int NUM_SLOTS = 1 << ID_W;

  logic rd_int, lastin_int, wait_int;
  logic ready_int, busy_int, soc_int, idle_int;
  logic [NUM_SLOTS*DATA_W-1:0] regs_flat;

  assign rd_int     = (rd_i == RD_HI);
  assign lastin_int = (lastin_i == LASTIN_HI);
  assign wait_int   = (wait_i == WAIT_HI);

  acq_input_bank #(.DATA_W(DATA_W), .ID_W(ID_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (idle_int),
    .rd_i     (rd_int),
    .sel_i    (sel_i),
    .data_i   (data_i),
    .ready_o  (ready_int),
    .regs_o   (regs_flat)
  );

  acq_out_seq #(
    .DATA_W(DATA_W), .ID_W(ID_W), .NUM_OUT(NUM_OUT), .CALC_LAT(CALC_LAT)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lastin_i  (lastin_int),
    .wait_i    (wait_int),
    .auto_i    (auto_i),
    .regs_i    (regs_flat),
    .busy_o    (busy_int),
    .idle_o    (idle_int),
    .out_o     (out_o),
    .out_stb_o (out_stb_o),
    .out_idx_o (out_idx_o),
    .soc_o     (soc_int)
  );

  assign ready_o  = READY_HI ? ready_int : ~ready_int;
  assign busy_o   = BUSY_HI  ? busy_int  : ~busy_int;
  assign soc_o    = SOC_HI   ? soc_int   : ~soc_int;
  assign out_en_o = ~oe_ni;
endmodule

// File: rtl/slave_acq_seq_chk.sv
module slave_acq_seq_chk #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          auto_i,
  input logic                          ready_i,
  input logic                          busy_i,
  input logic                          soc_i,
  input logic                          stb_i,
  input logic                          wait_i,
  input logic [(1<<ID_W)*DATA_W-1:0]   regs_i
);
  a_r4_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> !ready_i);

  a_r3_slots_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(regs_i));

  a_r8_soc_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i |-> (!busy_i && $past(busy_i)));

  a_r8_auto_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i |-> !$past(auto_i));

  a_r7_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |-> !$past(wait_i));

  a_r5_stb_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |-> $past(busy_i));
endmodule

bind slave_acq_seq slave_acq_seq_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .auto_i  (auto_i),
  .ready_i (ready_int),
  .busy_i  (busy_int),
  .soc_i   (soc_int),
  .stb_i   (out_stb_o),
  .wait_i  (wait_int),
  .regs_i  (regs_flat)
);

// File: tb/slave_acq_seq_test.sv
module slave_acq_seq_test;
  localparam int NUM_OUT  = 4;
  localparam int CALC_LAT = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       auto_i = 1'b0, rd_i = 1'b0, lastin_i = 1'b0, wait_i = 1'b0, oe_ni = 1'b0;
  logic [2:0] sel_i = '0;
  logic [7:0] data_i = '0;
  logic       ready_o, busy_o, soc_o, out_en_o, out_stb_o;
  logic [7:0] out_o;
  logic [1:0] out_idx_o;

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] model [8];

  always #2.5 clk = ~clk;

  slave_acq_seq #(.NUM_OUT(NUM_OUT), .CALC_LAT(CALC_LAT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .auto_i(auto_i), .rd_i(rd_i), .sel_i(sel_i),
    .data_i(data_i), .lastin_i(lastin_i), .wait_i(wait_i), .oe_ni(oe_ni),
    .ready_o(ready_o), .busy_o(busy_o), .soc_o(soc_o), .out_o(out_o),
    .out_en_o(out_en_o), .out_stb_o(out_stb_o), .out_idx_o(out_idx_o)
  );

  function automatic logic [7:0] exp_out(int k);
    return 8'(model[k % 8] + model[(k + 1) % 8] + 8'(k));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // R1 R4: capture while idle
  task automatic write_in(logic [2:0] id, logic [7:0] d);
    @(negedge clk);
    sel_i = id; data_i = d; rd_i = 1'b1;
    @(negedge clk);
    chk(ready_o == 1'b1, "R4 ready pulse", ready_o, 1);
    rd_i = 1'b0;
    model[id] = d;
    @(negedge clk);
    chk(ready_o == 1'b0, "R4 ready one cycle", ready_o, 0);
  endtask

  // R5 R6 R7 R8 R3: one processing run
  task automatic run(bit rnd_wait, bit inject, bit auto_v);
    int k = 0, last = 0;
    bit wdrv = 1'b0, wprev;
    @(negedge clk);
    auto_i = auto_v; lastin_i = 1'b1;
    @(negedge clk);
    lastin_i = 1'b0;
    chk(busy_o == 1'b1, "R5 busy rises", busy_o, 1);
    for (int n = 0; n < 2000; n++) begin
      if (out_stb_o) begin
        chk(out_idx_o == 2'(k), "R6 index", out_idx_o, k);
        chk(out_o == exp_out(k), "R6 value", out_o, exp_out(k));
        chk(wdrv == 1'b0, "R7 presented while wait", wdrv, 0);
        if (!rnd_wait) chk(n - last == CALC_LAT, "R6 spacing", n - last, CALC_LAT);
        last = n;
        k++;
      end
      if (!busy_o) begin
        chk(k == NUM_OUT, "R5 output count", k, NUM_OUT);
        chk(soc_o == !auto_v, "R8 soc at end", soc_o, !auto_v);
        break;
      end
      if (inject && n == 3) begin
        chk(ready_o == 1'b0, "R3 no ready while busy", ready_o, 0);
        rd_i = 1'b0;
      end
      if (inject && n == 2) begin
        sel_i = 3'($urandom); data_i = 8'($urandom); rd_i = 1'b1;
      end
      wprev = rnd_wait ? ($urandom % 3 == 0) : 1'b0;
      if (!out_stb_o && k > 0 && wdrv) begin
        // R7: held value does not move while waiting
        chk(out_o == exp_out(k - 1), "R7 held output", out_o, exp_out(k - 1));
      end
      wdrv = wprev;
      wait_i = wdrv;
      @(negedge clk);
    end
    wait_i = 1'b0; rd_i = 1'b0;
    @(negedge clk);
    chk(soc_o == 1'b0, "R8 soc one cycle", soc_o, 0);
    auto_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && ready_o == 0 && soc_o == 0 && out_o == 0 && out_stb_o == 0,
        "R5 reset state", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 output enable
    oe_ni = 1'b1; #1;
    chk(out_en_o == 1'b0, "R9 disabled", out_en_o, 0);
    oe_ni = 1'b0; #1;
    chk(out_en_o == 1'b1, "R9 enabled", out_en_o, 1);

    // R1 R2 R10: all slots, out of order, default active-high pins
    for (int i = 7; i >= 0; i--) write_in(3'(i), 8'(8'h11 * (i + 1)));
    run(1'b0, 1'b0, 1'b0);
    // R2 persistence: one slot rewritten, rest kept
    write_in(3'd1, 8'hF0);
    run(1'b0, 1'b0, 1'b0);
    // R3 write during run, then rerun without rewriting
    run(1'b0, 1'b1, 1'b0);
    run(1'b1, 1'b0, 1'b0);
    // R8 auto suppresses soc
    run(1'b0, 1'b0, 1'b1);

    for (int r = 0; r < 25; r++) begin
      int nw = int'($urandom % 5);
      for (int w = 0; w < nw; w++) write_in(3'($urandom), 8'($urandom));
      run(1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule